// File: doc/BRIEF.md
# Banked Data-Register Front End

This block sits between an 8-bit core's execute stage and its data memory. The core presents a 7-bit direct location, a read strobe, a write strobe with a data byte, and a set of per-flag update enables from the ALU. The block forms an 8-bit effective address from these inputs. It takes the bank bit from the status register, or it takes the whole address from an 8-bit pointer register when the direct location is zero. It then routes the access to one of four places: the status register, the pointer register, a shared general-purpose RAM, or an external port where the peripheral registers live.

The status register is owned here. It carries the bank-select bit, two health bits (time-out and power-down) that software cannot write, and the zero, digit-carry and carry flags. The ALU flag logic has priority over software writes to the flag bits. The RAM appears at the same locations in both banks. Locations beyond the RAM read as zero and ignore writes. Read data is registered and appears one cycle after the strobe.

Top module: `bank_regfile`

## Requirements
- R1: A power-on reset (`rst` with `rst_por`=1) sets the status register to 18h (bit 4 time-out = 1, bit 3 power-down = 1, bank bit 5 = 0, flags Z bit 2, DC bit 1, C bit 0 all 0), sets the pointer to 00h and sets `rd_data` to 00h.
- R2: A pin reset (`rst` with `rst_por`=0) clears status bits 7:5 and leaves bits 4:0 unchanged.
- R3: For a direct access, status bit 5 is bit 7 of the effective address. `bank_sel` equals that bit.
- R4: Locations 0Ch-4Fh are 68 RAM bytes shared by both banks, so 0Ch and 8Ch reach the same byte.
- R5: Direct location 00h makes the pointer register (location 04h) the effective address. Pointer bit 7 gives the bank and bits 6:0 give the location, whatever the status bank bit holds.
- R6: An indirect access whose pointer location bits are 00h reads 00h and changes no register, RAM byte or peripheral.
- R7: Locations 50h-7Fh of either bank read 00h, and writes to them have no effect.
- R8: A write to the status register (location 03h) changes bit 5 and, when no flag update is enabled, bits 2:0. Bits 7:6 always read 0. Bits 4:3 are never written.
- R9: When a status write and any flag enable (`flg_we` bit 2 = Z, bit 1 = DC, bit 0 = C) fall in the same cycle, the written bits 2:0 are discarded. Enabled flags take `flg_val`, and the other flags keep their values, so clearing the register gives 000u u1uu.
- R10: A flag update without a status write changes only the enabled flag bits.
- R11: Locations 01h, 02h and 05h-0Bh of either bank go to the peripheral port. The port carries the 8-bit effective address and a one-cycle `per_rd` or `per_wr` strobe, and `rd_data` takes `per_rdata`.
- R12: `rd_data` shows the selected value one cycle after a read strobe. It holds while no read is strobed, and a read that coincides with a write returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rst_por | input | 1 | Reset kind: 1 power-on, 0 pin reset |
| addr | input | 7 | Direct location within the selected bank |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| flg_we | input | 3 | Flag update enables {Z, DC, C} |
| flg_val | input | 3 | Flag values from the ALU {Z, DC, C} |
| rd_data | output | 8 | Registered read data |
| bank_sel | output | 1 | Current bank-select bit |
| per_addr | output | 8 | Effective address toward the peripherals |
| per_rd | output | 1 | Peripheral read strobe |
| per_wr | output | 1 | Peripheral write strobe |
| per_wdata | output | 8 | Peripheral write data |
| per_rdata | input | 8 | Peripheral read data, combinational to `per_addr` |

## Verification
A write takes effect at the clock edge that samples the strobe. The read data register loads at that same edge, so a read result is due exactly one cycle after its strobe. Each bench task drives a stimulus at a falling edge and drops it at the next falling edge, then samples `rd_data` there, which is half a cycle after the loading edge. Peripheral strobes are combinational with the request, and flag and bank changes are visible from the edge that samples them. The bench therefore reads the peripheral model and `bank_sel` at the falling edge after the stimulus.

// File: rtl/brf_pkg.sv
package brf_pkg;
    localparam int DATA_W     = 8;
    localparam int SFR_STATUS = 3;
    localparam int SFR_PTR    = 4;
    localparam int ST_C       = 0;
    localparam int ST_DC      = 1;
    localparam int ST_Z       = 2;
    localparam int ST_PD      = 3;
    localparam int ST_TO      = 4;
    localparam int ST_BANK    = 5;
    localparam logic [DATA_W-1:0] ST_POR_VAL = 8'h18;

    typedef enum logic [2:0] {
        RG_NULL,
        RG_STATUS,
        RG_PTR,
        RG_PERIPH,
        RG_GPR,
        RG_NONE
    } region_e;

    typedef struct packed {
        logic [DATA_W-1:0] ptr;
        logic [DATA_W-1:0] rdat;
    } front_s;
endpackage

// File: rtl/brf_decode.sv
module brf_decode
    import brf_pkg::*;
#(
    parameter int LOC_W     = 7,
    parameter int GPR_BASE  = 12,
    parameter int GPR_COUNT = 68,
    parameter int IDX_W     = 7
) (
    input  logic [LOC_W-1:0] dir_loc,
    input  logic             bank_bit,
    input  logic [LOC_W:0]   ptr,
    output logic [LOC_W:0]   eff_addr,
    output region_e          region,
    output logic [IDX_W-1:0] gpr_idx
);
    localparam int GPR_END = GPR_BASE + GPR_COUNT;

    logic [LOC_W-1:0] loc;

    always_comb begin
        if (dir_loc == '0) begin
            eff_addr = ptr;
        end else begin
            eff_addr = {bank_bit, dir_loc};
        end
        loc     = eff_addr[LOC_W-1:0];
        gpr_idx = IDX_W'(loc - LOC_W'(GPR_BASE));

        if (loc == '0) begin
            region = RG_NULL;
        end else if (loc == LOC_W'(SFR_STATUS)) begin
            region = RG_STATUS;
        end else if (loc == LOC_W'(SFR_PTR)) begin
            region = RG_PTR;
        end else if (int'(loc) < GPR_BASE) begin
            region = RG_PERIPH;
        end else if (int'(loc) < GPR_END) begin
            region = RG_GPR;
        end else begin
            region = RG_NONE;
        end
    end
endmodule

// File: rtl/brf_status.sv
module brf_status
    import brf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rst_por,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        flg_we,
    input  logic [2:0]        flg_val,
    output logic [DATA_W-1:0] stat_q
);
    localparam logic [DATA_W-1:0] BANK_MASK = DATA_W'(1) << ST_BANK;
    localparam logic [DATA_W-1:0] FLAG_MASK = DATA_W'(7);
    localparam logic [DATA_W-1:0] HIGH_MASK = DATA_W'(8'hE0);

    logic [DATA_W-1:0] stat_d;
    logic [DATA_W-1:0] wmask;

    always_comb begin
        stat_d = stat_q;
        wmask  = '0;
        if (rst) begin
            if (rst_por) begin
                stat_d = ST_POR_VAL;
            end else begin
                stat_d = stat_q & ~HIGH_MASK;
            end
        end else begin
            if (wr_en) begin
                wmask = BANK_MASK;
                if (flg_we == 3'b000) begin
                    wmask = wmask | FLAG_MASK;
                end
            end
            stat_d = (stat_q & ~wmask) | (wr_data & wmask);
            for (int i = 0; i < 3; i++) begin
                if (flg_we[i]) begin
                    stat_d[i] = flg_val[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        stat_q <= stat_d;
    end

    // R8: reserved bits never read as 1
    p_rsv_zero_r8: assert property (@(posedge clk) disable iff (rst)
        stat_q[7:6] == 2'b00);

    // R8: health bits only move on reset
    p_health_hold_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(stat_q[ST_TO:ST_PD]));

    // R9: an enabled zero flag wins over a software write
    p_flag_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && flg_we[ST_Z]) |=> stat_q[ST_Z] == $past(flg_val[ST_Z]));

    // R10: a disabled flag with no write is left alone
    p_flag_keep_r10: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !flg_we[ST_C]) |=> $stable(stat_q[ST_C]));
endmodule

// File: rtl/brf_gpr.sv
module brf_gpr #(
    parameter int DEPTH  = 68,
    parameter int IDX_W  = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_comb begin
        if (int'(idx) < DEPTH) begin
            rdata = mem[idx];
        end else begin
            rdata = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem[idx] <= wdata;
        end
    end
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
    import brf_pkg::*;
#(
    parameter int LOC_W     = 7,
    parameter int GPR_BASE  = 12,
    parameter int GPR_COUNT = 68
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rst_por,
    input  logic [6:0]       addr,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic [2:0]       flg_we,
    input  logic [2:0]       flg_val,
    output logic [7:0]       rd_data,
    output logic             bank_sel,
    output logic [7:0]       per_addr,
    output logic             per_rd,
    output logic             per_wr,
    output logic [7:0]       per_wdata,
    input  logic [7:0]       per_rdata
);
    localparam int ADDR_W = LOC_W + 1;
    localparam int IDX_W  = $clog2(GPR_COUNT);

    front_s            cur_q;
    front_s            nxt_d;
    logic [DATA_W-1:0] stat_q;
    logic [ADDR_W-1:0] eff_addr;
    region_e           region;
    logic [IDX_W-1:0]  gpr_idx;
    logic [DATA_W-1:0] gpr_rdata;
    logic              live;
    logic              stat_wr;
    logic              gpr_we;

    brf_decode #(
        .LOC_W(LOC_W), .GPR_BASE(GPR_BASE), .GPR_COUNT(GPR_COUNT), .IDX_W(IDX_W)
    ) u_dec (
        .dir_loc (addr),
        .bank_bit(stat_q[ST_BANK]),
        .ptr     (cur_q.ptr),
        .eff_addr(eff_addr),
        .region  (region),
        .gpr_idx (gpr_idx)
    );

    brf_status u_stat (
        .clk    (clk),
        .rst    (rst),
        .rst_por(rst_por),
        .wr_en  (stat_wr),
        .wr_data(wr_data),
        .flg_we (flg_we),
        .flg_val(flg_val),
        .stat_q (stat_q)
    );

    brf_gpr #(
        .DEPTH(GPR_COUNT), .IDX_W(IDX_W), .DATA_W(DATA_W)
    ) u_gpr (
        .clk  (clk),
        .we   (gpr_we),
        .idx  (gpr_idx),
        .wdata(wr_data),
        .rdata(gpr_rdata)
    );

    always_comb begin
        live    = !rst;
        stat_wr = live && wr_en && (region == RG_STATUS);
        gpr_we  = live && wr_en && (region == RG_GPR);
        per_rd  = live && rd_en && (region == RG_PERIPH);
        per_wr  = live && wr_en && (region == RG_PERIPH);

        nxt_d = cur_q;
        if (rst) begin
            nxt_d.ptr  = '0;
            nxt_d.rdat = '0;
        end else begin
            if (rd_en) begin
                unique case (region)
                    RG_STATUS: nxt_d.rdat = stat_q;
                    RG_PTR:    nxt_d.rdat = cur_q.ptr;
                    RG_PERIPH: nxt_d.rdat = per_rdata;
                    RG_GPR:    nxt_d.rdat = gpr_rdata;
                    default:   nxt_d.rdat = '0;
                endcase
            end
            if (wr_en && (region == RG_PTR)) begin
                nxt_d.ptr = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        cur_q <= nxt_d;
    end

    assign rd_data   = cur_q.rdat;
    assign bank_sel  = stat_q[ST_BANK];
    assign per_addr  = eff_addr;
    assign per_wdata = wr_data;

    // R12: read data holds without a strobe
    p_rd_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    // R11: peripheral strobes follow the core strobes
    p_per_strobe_r11: assert property (@(posedge clk) disable iff (rst)
        (per_rd |-> rd_en) and (per_wr |-> wr_en));

    // R6: the null location never reaches the peripheral port
    p_null_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (per_rd || per_wr) |-> (per_addr[LOC_W-1:0] != '0));

    // R4: RAM writes stay inside the array
    p_gpr_idx_r4: assert property (@(posedge clk) disable iff (rst)
        gpr_we |-> (int'(gpr_idx) < GPR_COUNT));

    // R5: pointer only moves when written
    p_ptr_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cur_q.ptr));
endmodule

// File: tb/tb_bank_regfile.sv
module tb_bank_regfile;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rst_por = 1'b1;
    logic [6:0] addr = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [2:0] flg_we = '0;
    logic [2:0] flg_val = '0;
    logic [7:0] rd_data;
    logic       bank_sel;
    logic [7:0] per_addr;
    logic       per_rd;
    logic       per_wr;
    logic [7:0] per_wdata;
    logic [7:0] per_rdata;

    logic [7:0] per_mem [256];
    int         per_wr_cnt = 0;
    logic [7:0] last_wr_addr = '0;
    logic [7:0] last_rd_addr = '0;
    int         checks = 0;
    int         fails = 0;

    always #4 clk = ~clk;

    bank_regfile dut (
        .clk(clk), .rst(rst), .rst_por(rst_por), .addr(addr),
        .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
        .flg_we(flg_we), .flg_val(flg_val), .rd_data(rd_data),
        .bank_sel(bank_sel), .per_addr(per_addr), .per_rd(per_rd),
        .per_wr(per_wr), .per_wdata(per_wdata), .per_rdata(per_rdata)
    );

    always_comb per_rdata = per_mem[per_addr];

    always @(posedge clk) begin
        if (per_wr) begin
            per_mem[per_addr] <= per_wdata;
            last_wr_addr <= per_addr;
            per_wr_cnt = per_wr_cnt + 1;
        end
        if (per_rd) last_rd_addr <= per_addr;
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic step_io(input logic [6:0] a, input logic rd, input logic wr,
                           input logic [7:0] d, input logic [2:0] fwe, input logic [2:0] fv);
        @(negedge clk);
        addr = a; rd_en = rd; wr_en = wr; wr_data = d; flg_we = fwe; flg_val = fv;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0; flg_we = '0; flg_val = '0;
    endtask

    task automatic wr_reg(input logic [6:0] a, input logic [7:0] d);
        step_io(a, 1'b0, 1'b1, d, 3'b000, 3'b000);
    endtask

    task automatic rd_reg(input logic [6:0] a, output logic [7:0] v);
        step_io(a, 1'b1, 1'b0, 8'h00, 3'b000, 3'b000);
        v = rd_data;
    endtask

    task automatic t_por();
        logic [7:0] v;
        check("R1 rd_data after reset", rd_data, 8'h00);
        check("R1 bank_sel after reset", {7'b0, bank_sel}, 8'h00);
        rd_reg(7'h03, v); check("R1 status after power-on", v, 8'h18);
        rd_reg(7'h04, v); check("R1 pointer after power-on", v, 8'h00);
    endtask

    task automatic t_status_write();
        logic [7:0] v;
        wr_reg(7'h03, 8'hFF);
        check("R3 bank_sel set", {7'b0, bank_sel}, 8'h01);
        rd_reg(7'h03, v); check("R8 status after FF write", v, 8'h3F);
        wr_reg(7'h03, 8'h00);
        rd_reg(7'h03, v); check("R8 status after 00 write", v, 8'h18);
    endtask

    task automatic t_flag_merge();
        logic [7:0] v;
        wr_reg(7'h03, 8'h27);
        step_io(7'h03, 1'b0, 1'b1, 8'h00, 3'b100, 3'b100);
        rd_reg(7'h03, v); check("R9 clear with Z update", v, 8'h1F);
        step_io(7'h03, 1'b0, 1'b1, 8'hE0, 3'b001, 3'b000);
        rd_reg(7'h03, v); check("R9 write with C update", v, 8'h3E);
    endtask

    task automatic t_flag_only();
        logic [7:0] v;
        step_io(7'h0C, 1'b0, 1'b0, 8'h00, 3'b011, 3'b001);
        rd_reg(7'h03, v); check("R10 flag update only", v, 8'h3D);
        wr_reg(7'h03, 8'h00);
    endtask

    task automatic t_bank_direct();
        wr_reg(7'h03, 8'h20);
        check("R3 bank_sel bank 1", {7'b0, bank_sel}, 8'h01);
        wr_reg(7'h05, 8'h6B);
        check("R3 bank1 write reaches 85h", per_mem[8'h85], 8'h6B);
        check("R3 bank1 write misses 05h", per_mem[8'h05], 8'h00);
        wr_reg(7'h03, 8'h00);
        wr_reg(7'h05, 8'h14);
        check("R3 bank0 write reaches 05h", per_mem[8'h05], 8'h14);
        check("R3 85h left alone", per_mem[8'h85], 8'h6B);
    endtask

    task automatic t_mirror();
        logic [7:0] v;
        wr_reg(7'h0C, 8'hA5);
        wr_reg(7'h03, 8'h20);
        rd_reg(7'h0C, v); check("R4 8Ch mirrors 0Ch", v, 8'hA5);
        wr_reg(7'h4F, 8'h5A);
        wr_reg(7'h03, 8'h00);
        rd_reg(7'h4F, v); check("R4 4Fh mirrors CFh", v, 8'h5A);
    endtask

    task automatic t_unimpl();
        logic [7:0] v;
        int c0;
        c0 = per_wr_cnt;
        wr_reg(7'h50, 8'h77);
        rd_reg(7'h50, v); check("R7 50h reads zero", v, 8'h00);
        rd_reg(7'h4F, v); check("R7 neighbour 4Fh intact", v, 8'h5A);
        wr_reg(7'h03, 8'h20);
        wr_reg(7'h7F, 8'h99);
        rd_reg(7'h7F, v); check("R7 FFh reads zero", v, 8'h00);
        wr_reg(7'h03, 8'h00);
        check("R7 no peripheral write", 8'(per_wr_cnt - c0), 8'h00);
    endtask

    task automatic t_indirect();
        logic [7:0] v;
        wr_reg(7'h04, 8'h8D);
        wr_reg(7'h00, 8'h3C);
        rd_reg(7'h0D, v); check("R5 indirect write to 8Dh", v, 8'h3C);
        rd_reg(7'h04, v); check("R5 pointer readback", v, 8'h8D);
        wr_reg(7'h04, 8'h83);
        rd_reg(7'h00, v); check("R5 indirect status read", v, 8'h18);
        wr_reg(7'h04, 8'h86);
        wr_reg(7'h00, 8'hC3);
        check("R5 indirect bank from pointer", per_mem[8'h86], 8'hC3);
        check("R5 peripheral address", last_wr_addr, 8'h86);
    endtask

    task automatic t_null();
        logic [7:0] v;
        int c0;
        wr_reg(7'h04, 8'h00);
        rd_reg(7'h00, v); check("R6 null read", v, 8'h00);
        c0 = per_wr_cnt;
        wr_reg(7'h00, 8'h55);
        rd_reg(7'h04, v); check("R6 pointer kept", v, 8'h00);
        rd_reg(7'h03, v); check("R6 status kept", v, 8'h18);
        rd_reg(7'h0C, v); check("R6 RAM kept", v, 8'hA5);
        check("R6 no peripheral write", 8'(per_wr_cnt - c0), 8'h00);
        wr_reg(7'h04, 8'h80);
        rd_reg(7'h00, v); check("R6 null read bank 1", v, 8'h00);
    endtask

    task automatic t_periph();
        logic [7:0] v;
        int c0;
        c0 = per_wr_cnt;
        wr_reg(7'h0B, 8'h9D);
        check("R11 one write strobe", 8'(per_wr_cnt - c0), 8'h01);
        rd_reg(7'h0B, v); check("R11 peripheral read data", v, 8'h9D);
        check("R11 peripheral read address", last_rd_addr, 8'h0B);
    endtask

    task automatic t_read_timing();
        logic [7:0] v;
        wr_reg(7'h30, 8'h11);
        rd_reg(7'h30, v); check("R12 read result", v, 8'h11);
        for (int i = 0; i < 3; i++) begin
            wr_reg(7'h31, 8'(i));
            check("R12 hold without strobe", rd_data, 8'h11);
        end
        step_io(7'h30, 1'b1, 1'b1, 8'h22, 3'b000, 3'b000);
        check("R12 read during write", rd_data, 8'h11);
        rd_reg(7'h30, v); check("R12 read after write", v, 8'h22);
    endtask

    task automatic t_pin_reset();
        logic [7:0] v;
        wr_reg(7'h03, 8'h27);
        step_io(7'h00, 1'b0, 1'b0, 8'h00, 3'b111, 3'b010);
        @(negedge clk);
        rst = 1'b1; rst_por = 1'b0;
        @(negedge clk);
        rst = 1'b0; rst_por = 1'b1;
        check("R2 bank cleared", {7'b0, bank_sel}, 8'h00);
        rd_reg(7'h03, v); check("R2 status after pin reset", v, 8'h1A);
        rd_reg(7'h30, v); check("R2 RAM kept", v, 8'h22);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) per_mem[i] = 8'h00;
    end

    initial begin
        repeat (60000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_por();
        t_status_write();
        t_flag_merge();
        t_flag_only();
        t_bank_direct();
        t_mirror();
        t_unimpl();
        t_indirect();
        t_null();
        t_periph();
        t_read_timing();
        t_pin_reset();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule